// File: doc/BRIEF.md
# I2C Slave Disable-Status Tracker

This block sits beside an I2C slave protocol engine and owns the shutdown handshake. Software drops its enable bit at any moment. The effective enable handed to the rest of the controller stays high until the bus reaches a point where the slave can let go safely. That point is a STOP, a bus-idle indication, or the end of a byte that the slave was told to NACK. While it waits, the block asks the engine to NACK whatever transfer is in flight.

The block also records why a transfer was cut short. Two abort-cause flags are latched in the same clock edge that drops the effective enable. One says the slave was busy. The other says received data was lost. A 32-bit read-only status word carries the effective enable in bit 0 and the two flags in bits 1 and 2. The flags are meaningful only once bit 0 reads 0.

The engine is represented by level and strobe inputs only: address byte in progress, address match with its direction, data phase entered, byte received, STOP and bus idle.

Top module: `i2c_slv_dis_track`

## Requirements
- R1: `stat_o[0]` always equals `eff_en_o`, and `stat_o[31:3]` is always zero.
- R2: While `sw_en_i` is 1, `eff_en_o` is 1 and `stat_o` reads 32'h1 in the same cycle.
- R3: After `sw_en_i` goes to 0, `eff_en_o` stays 1 until a cycle in which the disable is pending and `stop_i` or `idle_i` is high, or `byte_rx_i` is high while `force_nack_o` is high. `eff_en_o` reads 0 from the cycle after that event.
- R4: `force_nack_o` is 1 exactly while a disable is pending and the slave is busy. Busy means `addr_act_i` is high, or a matched write-direction transfer (`addr_match_i` with `match_rnw_i`=0) is in progress. A match has no effect on `force_nack_o` while `addr_act_i` is high.
- R5: At shutdown, bit 1 (busy) is set when the slave was busy in any cycle of the pending window. This includes a matched receive transfer that ends with the STOP causing shutdown.
- R6: Bit 1 stays 0 when the disable completes while the bus is idle, or during traffic for another address or a read-direction transfer with `addr_act_i` low.
- R7: At shutdown, bit 2 (data lost) is set when a matched receive transfer was in progress and had seen `data_ph_i`. Otherwise bit 2 is 0.
- R8: A STOP arriving in the same cycle as the disable, or in a later cycle while the disable is pending, during a matched receive data phase sets both bit 1 and bit 2.
- R9: While disabled, bits 2:1 hold their value whatever the engine inputs do. Both flags clear when `sw_en_i` returns to 1.
- R10: If `sw_en_i` returns to 1 before `eff_en_o` drops, `eff_en_o` never falls and no busy history carries into a later disable.
- R11: During and right after reset, `eff_en_o`, `force_nack_o` and `stat_o` are 0 while `sw_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_en_i | input | 1 | Software enable bit |
| addr_act_i | input | 1 | Address byte from a remote master is being received |
| addr_match_i | input | 1 | Strobe: address matched this slave |
| match_rnw_i | input | 1 | Direction sampled with the match (1 = read, slave transmits) |
| data_ph_i | input | 1 | Strobe: data phase of the transfer entered |
| byte_rx_i | input | 1 | Strobe: a byte completed on the bus |
| stop_i | input | 1 | Strobe: STOP condition detected |
| idle_i | input | 1 | Bus is idle |
| eff_en_o | output | 1 | Effective enable to the controller |
| force_nack_o | output | 1 | Request to the engine to NACK the current byte |
| stat_o | output | STAT_W | Status word: bit 0 enable, bit 1 busy, bit 2 data lost |

## Verification
The case to watch is a disable request and the shutdown event landing in the same cycle. This happens when the software write that clears the enable coincides with a STOP during a matched receive data phase. The drop, the busy latch and the data-lost latch then all resolve on one edge. The bench provokes this by lowering `sw_en_i` and pulsing `stop_i` together. It also lowers `sw_en_i` one cycle ahead of the STOP. In both cases it expects `stat_o` to read 3'b110 from the next cycle. A behavioural model built from the requirements is compared with every output on every clock throughout.

// File: rtl/i2c_dis_pkg.sv
package i2c_dis_pkg;
  localparam int unsigned ST_EN   = 0;
  localparam int unsigned ST_BUSY = 1;
  localparam int unsigned ST_LOST = 2;
  localparam int unsigned ST_USED = 3;

  typedef struct packed {
    logic lost;
    logic busy;
  } abort_t;
endpackage

// File: rtl/i2c_dis_xfer.sv
// Tracks a matched write-direction (slave receive) transfer and its data phase.
module i2c_dis_xfer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic match_i,
  input  logic rnw_i,
  input  logic data_ph_i,
  input  logic stop_i,
  input  logic idle_i,
  output logic rx_sel_o,
  output logic data_ph_o
);
  logic rx_q, dp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= 1'b0;
      dp_q <= 1'b0;
    end else if (stop_i || idle_i) begin
      rx_q <= 1'b0;
      dp_q <= 1'b0;
    end else begin
      if (en_i && match_i && !rnw_i) rx_q <= 1'b1;
      if (data_ph_i && rx_q)         dp_q <= 1'b1;
    end
  end

  assign rx_sel_o  = rx_q;
  assign data_ph_o = dp_q;
endmodule

// File: rtl/i2c_dis_ctrl.sv
// Enable handshake: enable is immediate, disable waits for a safe bus point.
module i2c_dis_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_en_i,
  input  logic addr_act_i,
  input  logic rx_sel_i,
  input  logic stop_i,
  input  logic idle_i,
  input  logic byte_rx_i,
  output logic eff_en_o,
  output logic pend_o,
  output logic busy_now_o,
  output logic nack_o,
  output logic shut_o
);
  logic run_q;

  assign pend_o     = run_q & ~sw_en_i;
  assign busy_now_o = addr_act_i | rx_sel_i;
  assign nack_o     = pend_o & busy_now_o;
  assign shut_o     = pend_o & (stop_i | idle_i | (nack_o & byte_rx_i));
  assign eff_en_o   = sw_en_i | run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (sw_en_i) run_q <= 1'b1;
    else if (shut_o)  run_q <= 1'b0;
  end
endmodule

// File: rtl/i2c_dis_cause.sv
// Abort-cause latch: gathers busy history during the pending window.
module i2c_dis_cause
  import i2c_dis_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sw_en_i,
  input  logic   pend_i,
  input  logic   shut_i,
  input  logic   busy_now_i,
  input  logic   lost_now_i,
  output abort_t flags_o
);
  logic   hit_q;
  abort_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      flags_q <= '0;
    end else if (sw_en_i) begin
      hit_q   <= 1'b0;
      flags_q <= '0;
    end else if (pend_i) begin
      hit_q <= hit_q | busy_now_i;
      if (shut_i) begin
        flags_q.busy <= hit_q | busy_now_i;
        flags_q.lost <= lost_now_i;
      end
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/i2c_slv_dis_track.sv
module i2c_slv_dis_track
  import i2c_dis_pkg::*;
#(
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_en_i,
  input  logic              addr_act_i,
  input  logic              addr_match_i,
  input  logic              match_rnw_i,
  input  logic              data_ph_i,
  input  logic              byte_rx_i,
  input  logic              stop_i,
  input  logic              idle_i,
  output logic              eff_en_o,
  output logic              force_nack_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam int unsigned PAD_W = STAT_W - ST_USED;

  logic   rx_sel, data_ph, pend, busy_now, shut;
  abort_t flags;

  i2c_dis_xfer u_xfer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (eff_en_o),
    .match_i   (addr_match_i),
    .rnw_i     (match_rnw_i),
    .data_ph_i (data_ph_i),
    .stop_i    (stop_i),
    .idle_i    (idle_i),
    .rx_sel_o  (rx_sel),
    .data_ph_o (data_ph)
  );

  i2c_dis_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_en_i    (sw_en_i),
    .addr_act_i (addr_act_i),
    .rx_sel_i   (rx_sel),
    .stop_i     (stop_i),
    .idle_i     (idle_i),
    .byte_rx_i  (byte_rx_i),
    .eff_en_o   (eff_en_o),
    .pend_o     (pend),
    .busy_now_o (busy_now),
    .nack_o     (force_nack_o),
    .shut_o     (shut)
  );

  i2c_dis_cause u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_en_i    (sw_en_i),
    .pend_i     (pend),
    .shut_i     (shut),
    .busy_now_i (busy_now),
    .lost_now_i (rx_sel & data_ph),
    .flags_o    (flags)
  );

  // Flags clear on the edge after re-enable; mask them in that cycle.
  always_comb begin
    stat_o          = '0;
    stat_o[ST_EN]   = eff_en_o;
    stat_o[ST_BUSY] = flags.busy & ~sw_en_i;
    stat_o[ST_LOST] = flags.lost & ~sw_en_i;
  end

  if (PAD_W == 0) begin : g_no_pad
  end else begin : g_pad
  end
endmodule

// File: rtl/i2c_slv_dis_track_chk.sv
module i2c_slv_dis_track_chk #(
  parameter int unsigned STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sw_en_i,
  input logic              byte_rx_i,
  input logic              stop_i,
  input logic              idle_i,
  input logic              eff_en_o,
  input logic              force_nack_o,
  input logic [STAT_W-1:0] stat_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_en_mirror_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[0] == eff_en_o);

  p_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[STAT_W-1:3] == '0);

  p_sw_forces_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_i |-> (eff_en_o && stat_o[2:1] == 2'b00));

  p_drop_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $fell(eff_en_o) |-> $past(stop_i || idle_i || byte_rx_i) && !$past(sw_en_i));

  p_nack_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_nack_o |-> (!sw_en_i && eff_en_o));

  p_lost_needs_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[2] |-> stat_o[1]);

  p_hold_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !sw_en_i && !eff_en_o && $past(!eff_en_o && !sw_en_i) |-> $stable(stat_o));
endmodule

bind i2c_slv_dis_track i2c_slv_dis_track_chk #(.STAT_W(STAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sw_en_i      (sw_en_i),
  .byte_rx_i    (byte_rx_i),
  .stop_i       (stop_i),
  .idle_i       (idle_i),
  .eff_en_o     (eff_en_o),
  .force_nack_o (force_nack_o),
  .stat_o       (stat_o)
);

// File: tb/tb_i2c_slv_dis_track.sv
`timescale 1ns/1ps
module tb_i2c_slv_dis_track;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_en = 0, addr_act = 0, match = 0, rnw = 0, dph = 0, brx = 0, stop = 0, idle = 0;
  logic eff_en, nack;
  logic [SW-1:0] stat;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slv_dis_track #(.STAT_W(SW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_en_i(sw_en), .addr_act_i(addr_act),
    .addr_match_i(match), .match_rnw_i(rnw), .data_ph_i(dph), .byte_rx_i(brx),
    .stop_i(stop), .idle_i(idle), .eff_en_o(eff_en), .force_nack_o(nack), .stat_o(stat)
  );

  task automatic chk(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: "alive" = shutdown not yet reached, "seen_busy" = busy history.
  bit m_alive, m_seen_busy, m_busy, m_lost, m_rx, m_dp;

  function automatic bit m_waiting();
    return m_alive && !sw_en;
  endfunction
  function automatic bit m_engaged();
    return addr_act || m_rx;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_alive, m_seen_busy, m_busy, m_lost, m_rx, m_dp} = '0;
    end else begin
      bit w, e, fin, on, rx0;
      w   = m_waiting();
      e   = m_engaged();
      fin = w && (stop || idle || (e && brx));
      on  = sw_en || m_alive;
      rx0 = m_rx;
      if (sw_en) begin
        m_alive = 1; m_seen_busy = 0; m_busy = 0; m_lost = 0;
      end else if (w) begin
        if (fin) begin
          m_busy  = m_seen_busy || e;
          m_lost  = m_rx && m_dp;
          m_alive = 0;
        end
        m_seen_busy = m_seen_busy || e;
      end
      if (stop || idle) begin
        m_rx = 0; m_dp = 0;
      end else begin
        if (on && match && !rnw) m_rx = 1;
        if (dph && rx0) m_dp = 1;
      end
    end
  end

  // Compare every output on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_en;
      exp_en = sw_en || m_alive;
      chk("R3 eff_en", {31'b0, eff_en}, {31'b0, exp_en});
      chk("R4 force_nack", {31'b0, nack}, {31'b0, m_waiting() && m_engaged()});
      chk("R1 bit0", {31'b0, stat[0]}, {31'b0, eff_en});
      chk("R1 upper", {3'b0, stat[31:3]}, '0);
      chk("R5 busy", {31'b0, stat[1]}, {31'b0, m_busy && !sw_en});
      chk("R7 lost", {31'b0, stat[2]}, {31'b0, m_lost && !sw_en});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    // R11 reset
    tick(2);
    at_neg();
    chk("R11 reset stat", stat, '0);
    chk("R11 reset en", {31'b0, eff_en}, '0);
    rst_n = 1;
    tick();
    at_neg();
    chk("R11 after reset", stat, '0);

    // R2 enable is immediate
    sw_en = 1;
    at_neg();
    chk("R2 enable same cycle", stat, 32'h1);
    tick(2);

    // R6 idle disable
    idle = 1;
    tick();
    sw_en = 0;
    at_neg();
    chk("R3 still enabled", {31'b0, eff_en}, 32'h1);
    tick();
    at_neg();
    chk("R6 idle disable", stat, 32'h0);

    // R4/R5 disable during a non-matching address byte
    sw_en = 1; idle = 0;
    tick(2);
    sw_en = 0; addr_act = 1;
    at_neg();
    chk("R4 nack during addr", {31'b0, nack}, 32'h1);
    tick(3);
    at_neg();
    chk("R3 waits for byte end", stat, 32'h1);
    tick();
    brx = 1;
    tick();
    brx = 0; addr_act = 0;
    at_neg();
    chk("R5 busy after addr abort", stat, 32'h2);

    // R6 traffic for another device
    sw_en = 1;
    tick(2);
    sw_en = 0;
    tick(4);
    at_neg();
    chk("R6 no nack for other device", {31'b0, nack}, 32'h0);
    chk("R3 waits for stop", stat, 32'h1);
    stop = 1;
    tick();
    stop = 0;
    at_neg();
    chk("R6 other device disable", stat, 32'h0);

    // R7 receive data phase abort
    sw_en = 1;
    tick();
    match = 1; rnw = 0;
    tick();
    match = 0; dph = 1;
    tick();
    dph = 0;
    tick();
    sw_en = 0;
    at_neg();
    chk("R4 nack in data phase", {31'b0, nack}, 32'h1);
    tick(2);
    brx = 1;
    tick();
    brx = 0;
    at_neg();
    chk("R7 data lost", stat, 32'h6);
    // R9 hold while disabled, even with bus events
    tick(3);
    idle = 1; addr_act = 1;
    tick(2);
    idle = 0; addr_act = 0;
    stop = 1;
    tick();
    stop = 0;
    at_neg();
    chk("R9 flags held", stat, 32'h6);
    sw_en = 1;
    at_neg();
    chk("R9 clear on re-enable", stat, 32'h1);
    tick();
    at_neg();
    chk("R9 cleared", stat, 32'h1);

    // R8 STOP in the same cycle as the disable
    match = 1;
    tick();
    match = 0; dph = 1;
    tick();
    dph = 0;
    tick();
    sw_en = 0; stop = 1;
    tick();
    stop = 0;
    at_neg();
    chk("R8 same-cycle stop", stat, 32'h6);

    // R8 STOP one cycle after the disable
    sw_en = 1;
    tick();
    match = 1;
    tick();
    match = 0; dph = 1;
    tick();
    dph = 0;
    tick();
    sw_en = 0;
    tick();
    stop = 1;
    tick();
    stop = 0;
    at_neg();
    chk("R8 stop after disable", stat, 32'h6);

    // R10 cancel before drop
    sw_en = 1;
    tick();
    match = 1;
    tick();
    match = 0;
    tick();
    sw_en = 0;
    at_neg();
    chk("R10 nack while pending", {31'b0, nack}, 32'h1);
    tick(2);
    sw_en = 1;
    at_neg();
    chk("R10 cancel keeps enable", stat, 32'h1);
    tick(2);
    stop = 1;
    tick();
    stop = 0; idle = 1;
    tick();
    sw_en = 0;
    tick();
    at_neg();
    chk("R10 no stale busy", stat, 32'h0);

    // R6 read-direction transfer does not count as busy
    sw_en = 1; idle = 0;
    tick();
    match = 1; rnw = 1;
    tick();
    match = 0; rnw = 0;
    tick();
    sw_en = 0;
    at_neg();
    chk("R6 no nack for read", {31'b0, nack}, 32'h0);
    tick();
    stop = 1;
    tick();
    stop = 0;
    at_neg();
    chk("R6 read transfer disable", stat, 32'h0);

    tick(3);
    done = 1;
    finish_run();
  end
endmodule